// File: doc/BRIEF.md
# Video Control Register Write Port

This block sits on the CPU I/O bus of a video controller and turns writes to a single port into updates of the controller's internal state. The top two bits of each data byte choose what the byte does. One function latches a pen index, or selects the border. A second stores a hardware colour code into whichever palette entry was latched earlier. A third sets the screen mode, the two ROM overlay enables and an interrupt-counter clear. The fourth function code belongs to another device and is ignored here. Nothing in the port can be read back.

The screen mode is written into a staging register. It reaches the display side only when the next horizontal sync edge arrives, so a mode change never lands in the middle of a scan line. The ROM enables, however, act at once on a combinational select. For every memory read this select tells the memory system whether the bottom or top 16 KiB window is served from ROM instead of RAM.

Top module: `vidctl_port`

## Requirements
- R1: After reset all 17 palette entries are 0, `pen_sel` is 0, `border_sel` is 0, `mode` is 0, and both `lower_rom_en` and `upper_rom_en` are 1.
- R2: A write (`io_wr`=1) has an effect only when `io_addr[15]`=0 and `io_addr[14]`=1. The remaining address bits do not matter, and a write to any other address leaves all state unchanged.
- R3: With data bits 7:6 = 00, bit 4 = 1 sets `border_sel` to 1 and leaves `pen_sel` unchanged. Bit 4 = 0 clears `border_sel` and loads `pen_sel` from bits 3:0. The selection then holds until the next such write.
- R4: With data bits 7:6 = 01, bits 4:0 are stored into palette entry 16 if `border_sel` is 1, and otherwise into entry `pen_sel`. No other entry changes. Entry k occupies `palette[5k+4:5k]`.
- R5: With data bits 7:6 = 10, from the next cycle `lower_rom_en` equals the inverse of bit 2 and `upper_rom_en` equals the inverse of bit 3.
- R6: `line_cnt_clr` is 1, in the same cycle, exactly when a decoded write has data bits 7:6 = 10 and bit 4 = 1.
- R7: A control write (bits 7:6 = 10) places bits 1:0 into a pending mode. `mode` takes the pending value only on a clock edge where `hsync_edge`=1. If a control write and `hsync_edge` fall in the same cycle, `mode` takes the value that was pending before that write.
- R8: A write with data bits 7:6 = 11 changes no state and does not raise `line_cnt_clr`.
- R9: `rom_sel` is 1 exactly when `mem_rd`=1 and either `mem_addr[15:14]`=00 with `lower_rom_en`=1, or `mem_addr[15:14]`=11 with `upper_rom_en`=1. When `mem_rd`=0 it is always 0, so writes go to RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current write |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| mem_addr | input | 16 | Memory address of the current access |
| mem_rd | input | 1 | Memory access is a read |
| hsync_edge | input | 1 | One-cycle pulse marking a horizontal sync edge |
| pen_sel | output | 4 | Latched pen number |
| border_sel | output | 1 | Border is the colour write target |
| palette | output | 85 | 17 entries of 5 bits; entry 16 is the border |
| mode | output | 2 | Active screen mode |
| lower_rom_en | output | 1 | Low 16 KiB read overlay enabled |
| upper_rom_en | output | 1 | High 16 KiB read overlay enabled |
| line_cnt_clr | output | 1 | Clear strobe for the line interrupt counter |
| rom_sel | output | 1 | Current memory read is served by ROM |

## Verification
The bench builds the block with 16 pens and 5-bit colour codes. With these values every pen number the 4-bit field can encode is reachable, entry 16 is reachable as the border, and every colour code can be stored. Directed writes and randomized traffic are mixed with decoded and undecoded addresses and with sync pulses that coincide with control writes, so the pending-versus-active mode corner is hit repeatedly. Reads sweep all four 16 KiB windows under every overlay combination.

// File: rtl/vidctl_port.sv
module vidctl_port #(
  parameter int NPEN = 16,
  parameter int CW   = 5,
  localparam int PW  = $clog2(NPEN),
  localparam int ENT = NPEN + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic [15:0]       mem_addr,
  input  logic              mem_rd,
  input  logic              hsync_edge,
  output logic [PW-1:0]     pen_sel,
  output logic              border_sel,
  output logic [ENT*CW-1:0] palette,
  output logic [1:0]        mode,
  output logic              lower_rom_en,
  output logic              upper_rom_en,
  output logic              line_cnt_clr,
  output logic              rom_sel
);

  logic       hit;
  logic [1:0] fn;
  logic       wr_pen, wr_col, wr_ctl;
  logic [PW:0] tgt;
  logic [1:0] mode_pend;
  logic       unused_ok;

  assign hit    = io_wr & ~io_addr[15] & io_addr[14];
  assign fn     = io_wdata[7:6];
  assign wr_pen = hit && fn == 2'b00;
  assign wr_col = hit && fn == 2'b01;
  assign wr_ctl = hit && fn == 2'b10;
  assign tgt    = border_sel ? (PW+1)'(ENT-1) : {1'b0, pen_sel};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pen_sel    <= '0;
      border_sel <= 1'b0;
    end else if (wr_pen) begin
      border_sel <= io_wdata[4];
      if (!io_wdata[4]) pen_sel <= io_wdata[PW-1:0];
    end
  end

  for (genvar k = 0; k < ENT; k++) begin : g_pal
    logic [CW-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q <= '0;
      else if (wr_col && tgt == (PW+1)'(k))
        ent_q <= io_wdata[CW-1:0];
    end
    assign palette[k*CW +: CW] = ent_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_pend    <= 2'b00;
      mode         <= 2'b00;
      lower_rom_en <= 1'b1;
      upper_rom_en <= 1'b1;
    end else begin
      if (hsync_edge) mode <= mode_pend;
      if (wr_ctl) begin
        mode_pend    <= io_wdata[1:0];
        lower_rom_en <= ~io_wdata[2];
        upper_rom_en <= ~io_wdata[3];
      end
    end
  end

  assign line_cnt_clr = wr_ctl & io_wdata[4];

  assign rom_sel = mem_rd &
                   ((mem_addr[15:14] == 2'b00 & lower_rom_en) |
                    (mem_addr[15:14] == 2'b11 & upper_rom_en));

  assign unused_ok = ^{io_addr[13:0], io_wdata, mem_addr[13:0]};

endmodule

// File: rtl/vidctl_port_chk.sv
module vidctl_port_chk #(
  parameter int NPEN = 16,
  parameter int CW   = 5,
  localparam int PW  = $clog2(NPEN),
  localparam int ENT = NPEN + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       io_addr,
  input logic [7:0]        io_wdata,
  input logic              io_wr,
  input logic [15:0]       mem_addr,
  input logic              mem_rd,
  input logic              hsync_edge,
  input logic [PW-1:0]     pen_sel,
  input logic              border_sel,
  input logic [ENT*CW-1:0] palette,
  input logic [1:0]        mode,
  input logic              lower_rom_en,
  input logic              upper_rom_en,
  input logic              line_cnt_clr,
  input logic              rom_sel
);

  a_r2_foreign_addr_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr[15:14] != 2'b01) |=>
      ($stable(palette) && $stable(pen_sel) && $stable(border_sel) &&
       $stable(lower_rom_en) && $stable(upper_rom_en)));

  a_r5_rom_flags_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr[15:14] == 2'b01 && io_wdata[7:6] == 2'b10) |=>
      (lower_rom_en == !$past(io_wdata[2]) && upper_rom_en == !$past(io_wdata[3])));

  a_r7_mode_waits_for_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_edge |=> $stable(mode));

  a_r8_func3_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_wdata[7:6] == 2'b11) |=>
      ($stable(palette) && $stable(pen_sel) && $stable(border_sel) &&
       $stable(lower_rom_en) && $stable(upper_rom_en)));

  a_r8_func3_no_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wdata[7:6] == 2'b11) |-> !line_cnt_clr);

  a_r9_write_goes_ram: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |-> !rom_sel);

  a_r9_middle_is_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[15] != mem_addr[14]) |-> !rom_sel);

  a_r3_border_keeps_pen: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr[15:14] == 2'b01 && io_wdata[7:6] == 2'b00 && io_wdata[4]) |=>
      (border_sel && $stable(pen_sel)));

endmodule

bind vidctl_port vidctl_port_chk #(.NPEN(NPEN), .CW(CW)) u_chk (.*);

// File: tb/tb_vidctl_port.sv
`timescale 1ns/1ps
module tb_vidctl_port;
  localparam int NPEN = 16;
  localparam int CW   = 5;
  localparam int ENT  = NPEN + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] io_addr, mem_addr;
  logic [7:0]  io_wdata;
  logic io_wr, mem_rd, hsync_edge;
  logic [3:0] pen_sel;
  logic border_sel;
  logic [ENT*CW-1:0] palette;
  logic [1:0] mode;
  logic lower_rom_en, upper_rom_en, line_cnt_clr, rom_sel;

  always #2.5 clk = ~clk;

  vidctl_port #(.NPEN(NPEN), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .hsync_edge(hsync_edge),
    .pen_sel(pen_sel), .border_sel(border_sel), .palette(palette), .mode(mode),
    .lower_rom_en(lower_rom_en), .upper_rom_en(upper_rom_en),
    .line_cnt_clr(line_cnt_clr), .rom_sel(rom_sel));

  int m_pal [ENT];
  int m_pen, m_brd, m_mpend, m_mode, m_lo, m_up;
  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < ENT; k++) m_pal[k] = 0;
    m_pen = 0; m_brd = 0; m_mpend = 0; m_mode = 0; m_lo = 1; m_up = 1;
  endtask

  task automatic check_regs(string req);
    chk(req, "pen_sel", int'(pen_sel), m_pen);
    chk(req, "border_sel", int'(border_sel), m_brd);
    chk("R7", "mode", int'(mode), m_mode);
    chk(req, "lower_rom_en", int'(lower_rom_en), m_lo);
    chk(req, "upper_rom_en", int'(upper_rom_en), m_up);
    for (int k = 0; k < ENT; k++)
      chk(req, $sformatf("palette[%0d]", k), int'(palette[k*CW +: CW]), m_pal[k]);
  endtask

  task automatic cyc(logic wr, logic [15:0] a, logic [7:0] d, logic hs, logic rd, logic [15:0] ma);
    bit hit;
    int exp_clr, exp_rom;
    io_wr = wr; io_addr = a; io_wdata = d; hsync_edge = hs; mem_rd = rd; mem_addr = ma;
    #1;
    hit = wr && !a[15] && a[14];
    exp_clr = (hit && d[7:6] == 2'b10 && d[4]) ? 1 : 0;
    exp_rom = (rd && ((ma[15:14] == 2'b00 && m_lo != 0) || (ma[15:14] == 2'b11 && m_up != 0))) ? 1 : 0;
    chk("R6", "line_cnt_clr", int'(line_cnt_clr), exp_clr);
    chk("R9", "rom_sel", int'(rom_sel), exp_rom);
    @(posedge clk);
    if (hs) m_mode = m_mpend;
    if (hit) begin
      case (d[7:6])
        2'b00: begin m_brd = d[4]; if (!d[4]) m_pen = d[3:0]; end
        2'b01: m_pal[m_brd != 0 ? NPEN : m_pen] = d[4:0];
        2'b10: begin m_mpend = d[1:0]; m_lo = d[2] ? 0 : 1; m_up = d[3] ? 0 : 1; end
        default: ;
      endcase
    end
    #1;
    check_regs(cur_req);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 16'h4000);
  endtask

  task automatic idle(logic hs);
    cyc(1'b0, 16'h0000, 8'h00, hs, 1'b0, 16'h4000);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_wr = 0; io_addr = 0; io_wdata = 0; hsync_edge = 0; mem_rd = 0; mem_addr = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1";
    check_regs("R1");
    idle(1'b0);

    cur_req = "R3";
    wr(16'h7F00, 8'h05);
    wr(16'h7F00, 8'h1F);
    wr(16'h7FAA, 8'h00);
    wr(16'h4000, 8'h0F);

    cur_req = "R4";
    wr(16'h7F00, 8'h4B);
    wr(16'h7F00, 8'h03);
    wr(16'h7F00, 8'h5F);
    wr(16'h7F00, 8'h11);
    wr(16'h7F00, 8'h54);
    wr(16'h7F00, 8'h41);
    wr(16'h7F00, 8'h0A);
    wr(16'h7F00, 8'h4E);

    cur_req = "R2";
    wr(16'hBF00, 8'h00);
    wr(16'h3F00, 8'h5F);
    wr(16'hFF12, 8'h8C);
    wr(16'h0000, 8'h1F);

    cur_req = "R8";
    wr(16'h7F00, 8'hC7);
    wr(16'h7F00, 8'hFF);

    cur_req = "R5";
    wr(16'h7F00, 8'h8E);
    for (int a = 0; a < 4; a++) cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b1, 16'(a << 14));
    wr(16'h7F00, 8'h84);
    for (int a = 0; a < 4; a++) cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b1, 16'((a << 14) | 16'h1234));
    wr(16'h7F00, 8'h88);
    for (int a = 0; a < 4; a++) cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b1, 16'((a << 14) | 16'h3FFF));
    wr(16'h7F00, 8'h80);

    cur_req = "R9";
    for (int a = 0; a < 4; a++) cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 16'(a << 14));

    cur_req = "R6";
    wr(16'h7F00, 8'h90);
    wr(16'h7F00, 8'h10);

    cur_req = "R7";
    wr(16'h7F00, 8'h82);
    idle(1'b0); idle(1'b0);
    idle(1'b1);
    cyc(1'b1, 16'h7F00, 8'h81, 1'b1, 1'b0, 16'h0);
    idle(1'b0);
    idle(1'b1);
    wr(16'h7F00, 8'h83);
    idle(1'b1);

    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      int sel = $urandom_range(0, 7);
      a = (sel < 5) ? {2'b01, 14'($urandom)} : 16'($urandom);
      d = 8'($urandom);
      cyc($urandom_range(0, 3) != 0, a, d, $urandom_range(0, 7) == 0,
          1'($urandom), 16'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule